// File: doc/BRIEF.md
# Write-Only Two-Channel Wiper Register Controller

This block is an I2C target that accepts writes only and keeps two 8-bit wiper position codes, channel A and channel B. It oversamples the bus clock and data lines with a faster system clock. It conditions both lines against short glitches and detects START and STOP conditions. It shifts bytes in most significant bit first and acknowledges by pulling the data line low through an open-drain enable.

A write is a START, then an address byte whose lowest bit is a write/no-operation flag, then a command byte that picks the target, then one or more data bytes, and finally a STOP. Each data byte takes effect on the selected code or codes as soon as its eighth bit is sampled, and a one-cycle strobe marks that update. Code 0x00 is the low-terminal end of a wiper and 0xFF is the high-terminal end. Three strap inputs supply the low address bits, so eight instances can share one bus.

Top module: `dual_wiper_i2c`

## Requirements
- R1: After reset both wiper codes equal 0x80, the update strobe is low and the data line is not driven.
- R2: The 7-bit address is binary 0101 followed by strap[2], strap[1], strap[0] (MSB first). A matching address byte is acknowledged. Any other address gets no acknowledge, and the bytes that follow are ignored until the next START.
- R3: An address byte whose bit 0 is 1 is a no-operation. It is acknowledged, but no later data byte in that transfer changes either code or raises the strobe.
- R4: With bit 0 of the address byte at 0, command 0x11 writes the data byte to code A only.
- R5: Command 0x12 writes the data byte to code B only.
- R6: Command 0x13 writes the same data byte to both codes, with a single strobe.
- R7: A command byte outside 0x11 to 0x13 is still acknowledged, but the data bytes after it change no code and raise no strobe.
- R8: For every accepted byte the block holds the data line low from the SCL fall after the 8th bit until the SCL fall after the 9th clock, and releases it at all other times.
- R9: Each further data byte in the same transfer repeats the update to the same target, with one strobe per byte.
- R10: A repeated START restarts address matching: bit and byte position return to the first address bit.
- R11: Pulses on SCL or SDA shorter than the filter window (FILT_LEN system clocks) do not count as clock edges, START or STOP.
- R12: The strobe is a single cycle high in exactly the cycle the new code first appears, and a code never changes without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_low | output | 1 | When high, the pad pulls the data line low (open-drain acknowledge) |
| strap | input | 3 | Low three address bits, strap[2] most significant |
| wiper_a | output | 8 | Position code of channel A |
| wiper_b | output | 8 | Position code of channel B |
| upd_pulse | output | 1 | One-cycle strobe for each applied data byte |

## Verification
A bit counter that slips or an acknowledge phase that is out of step shows up within the same byte. The acknowledge is then missing or sits on the wrong clock, so the bench sees it as a read-back of the data line during the ninth high phase. A wrong byte index or a stale command register does not appear until the next data byte. It then shows as a code landing in the wrong channel, or as an extra or missing strobe, so every transfer is followed by comparing both codes and the count of strobes. A filter that passes a glitch shifts every later bit of the byte, and the written code differs from the intended one in the same transfer.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] ADDR_PREFIX = 4'b0101;
  localparam logic [BYTE_W-1:0] MIDSCALE = 8'h80;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_ARM  = 2'd1,
    ACK_HOLD = 2'd2
  } ack_ph_t;

  function automatic logic addr_hit(input logic [6:0] addr, input logic [2:0] strap);
    return addr == {ADDR_PREFIX, strap};
  endfunction

  // bit 0 -> channel A, bit 1 -> channel B
  function automatic logic [1:0] cmd_route(input logic [BYTE_W-1:0] cmd);
    case (cmd)
      8'h11:   return 2'b01;
      8'h12:   return 2'b10;
      8'h13:   return 2'b11;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/dwc_line_filter.sv
module dwc_line_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt;
  logic          differs;

  assign differs = sync_q[1] != clean;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt    <= '0;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (!differs) begin
        cnt <= '0;
      end else if (cnt == CNT_LAST) begin
        cnt   <= '0;
        clean <= sync_q[1];
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_filter_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clean) |-> ($past(sync_q[1]) == clean));
endmodule

// File: rtl/dwc_bus_events.sv
module dwc_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start_ev = scl_q & scl & sda_q & ~sda;
  assign stop_ev  = scl_q & scl & ~sda_q & sda;
  assign scl_rise = ~scl_q & scl;
  assign scl_fall = scl_q & ~scl;
endmodule

// File: rtl/dual_wiper_i2c.sv
module dual_wiper_i2c
  import dwc_pkg::*;
#(
  parameter int FILT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_low,
  input  logic [2:0]        strap,
  output logic [BYTE_W-1:0] wiper_a,
  output logic [BYTE_W-1:0] wiper_b,
  output logic              upd_pulse
);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);

  logic scl_c, sda_c;
  logic start_ev, stop_ev, scl_rise, scl_fall;

  logic [1:0] raw_lines, clean_lines;
  assign raw_lines = {scl_i, sda_i};
  assign scl_c = clean_lines[1];
  assign sda_c = clean_lines[0];

  for (genvar g = 0; g < 2; g++) begin : g_filt
    dwc_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_lines[g]), .clean(clean_lines[g])
    );
  end

  dwc_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl(scl_c), .sda(sda_c),
    .start_ev(start_ev), .stop_ev(stop_ev), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  logic              active, nop_q, ack_ok;
  logic [BIT_CW-1:0] bitcnt;
  logic [1:0]        byte_idx;
  logic [6:0]        shreg;
  logic [BYTE_W-1:0] cmd_q;
  ack_ph_t           ack_ph;

  logic [BYTE_W-1:0] byte_in;
  logic              bit_take, byte_done, wr_fire;
  logic [1:0]        route;

  assign byte_in   = {shreg, sda_c};
  assign bit_take  = active & ~start_ev & ~stop_ev & scl_rise & (ack_ph == ACK_NONE);
  assign byte_done = bit_take & (bitcnt == LAST_BIT);
  assign route     = cmd_route(cmd_q);
  assign wr_fire   = byte_done & (byte_idx == 2'd2) & ~nop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      nop_q        <= 1'b0;
      ack_ok       <= 1'b0;
      bitcnt       <= '0;
      byte_idx     <= '0;
      shreg        <= '0;
      cmd_q        <= '0;
      ack_ph       <= ACK_NONE;
      sda_pull_low <= 1'b0;
      wiper_a      <= MIDSCALE;
      wiper_b      <= MIDSCALE;
      upd_pulse    <= 1'b0;
    end else begin
      upd_pulse <= 1'b0;
      if (start_ev) begin
        active       <= 1'b1;
        bitcnt       <= '0;
        byte_idx     <= '0;
        ack_ph       <= ACK_NONE;
        sda_pull_low <= 1'b0;
      end else if (stop_ev) begin
        active       <= 1'b0;
        ack_ph       <= ACK_NONE;
        sda_pull_low <= 1'b0;
      end else if (active) begin
        if (scl_fall && ack_ph == ACK_ARM) begin
          ack_ph       <= ACK_HOLD;
          sda_pull_low <= ack_ok;
        end else if (scl_fall && ack_ph == ACK_HOLD) begin
          ack_ph       <= ACK_NONE;
          sda_pull_low <= 1'b0;
          bitcnt       <= '0;
          if (byte_idx != 2'd2) byte_idx <= byte_idx + 1'b1;
          if (!ack_ok) active <= 1'b0;
        end else if (bit_take) begin
          shreg  <= byte_in[6:0];
          bitcnt <= bitcnt + 1'b1;
          if (byte_done) begin
            ack_ph <= ACK_ARM;
            ack_ok <= 1'b1;
            if (byte_idx == 2'd0) begin
              ack_ok <= addr_hit(byte_in[7:1], strap);
              nop_q  <= byte_in[0];
            end else if (byte_idx == 2'd1) begin
              cmd_q <= byte_in;
            end
          end
        end
      end
      if (wr_fire) begin
        if (route[0]) wiper_a <= byte_in;
        if (route[1]) wiper_b <= byte_in;
        upd_pulse <= |route;
      end
    end
  end

  assert_wiper_a_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_a) |-> upd_pulse);
  assert_wiper_b_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wiper_b) |-> upd_pulse);
  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |=> !upd_pulse);
  assert_nop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse |-> !nop_q);
  assert_ack_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> (ack_ph == ACK_HOLD));
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (bitcnt == '0 && byte_idx == 2'd0 && !sda_pull_low));
endmodule

// File: tb/dual_wiper_i2c_test.sv
`timescale 1ns/1ps
module dual_wiper_i2c_test;
  localparam int Q = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_pull_low, upd_pulse;
  logic [7:0] wiper_a, wiper_b;
  logic sda_bus;
  int n_chk = 0, n_bad = 0, pcount = 0;

  always #4 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull_low;

  dual_wiper_i2c uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_low(sda_pull_low), .strap(strap),
    .wiper_a(wiper_a), .wiper_b(wiper_b), .upd_pulse(upd_pulse)
  );

  always @(negedge clk) if (upd_pulse) pcount++;

  // {addr, cmd, data, exp_a, exp_b, exp_addr_ack, exp_pulses}
  localparam logic [41:0] VEC [8] = '{
    {8'h5A, 8'h11, 8'h3C, 8'h3C, 8'h80, 1'b1, 1'b1},  // R4
    {8'h5A, 8'h12, 8'hC5, 8'h3C, 8'hC5, 1'b1, 1'b1},  // R5
    {8'h5A, 8'h13, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1},  // R6
    {8'h5A, 8'h13, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1},  // R6
    {8'h5B, 8'h11, 8'h22, 8'hFF, 8'hFF, 1'b1, 1'b0},  // R3
    {8'h58, 8'h11, 8'h22, 8'hFF, 8'hFF, 1'b0, 1'b0},  // R2
    {8'h5A, 8'h27, 8'h44, 8'hFF, 8'hFF, 1'b1, 1'b0},  // R7
    {8'h5A, 8'h11, 8'h80, 8'h80, 8'hFF, 1'b1, 1'b1}   // R4
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b0; wq();
    scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl_m = 1'b1; wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq();
      scl_m = 1'b1; wq();
      if (glitch && i == 4) begin
        sda_m = 1'b0; repeat (3) @(negedge clk); sda_m = 1'b1;
      end
      wq();
      scl_m = 1'b0; wq();
      if (glitch && i == 4) begin
        scl_m = 1'b1; repeat (3) @(negedge clk); scl_m = 1'b0;
      end
    end
    sda_m = 1'b1; wq();
    scl_m = 1'b1; wq();
    ack = ~sda_bus;
    wq();
    scl_m = 1'b0; wq();
  endtask

  bit a0, a1, a2, a3;
  int p0;

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset wiper_a", wiper_a, 8'h80);
    chk("R1 reset wiper_b", wiper_b, 8'h80);
    chk("R1 reset sda", sda_pull_low, 0);
    chk("R1 reset strobe", upd_pulse, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after release wiper_a", wiper_a, 8'h80);

    for (int v = 0; v < 8; v++) begin
      p0 = pcount;
      bus_start();
      send_byte(VEC[v][41:34], 1'b0, a0);
      send_byte(VEC[v][33:26], 1'b0, a1);
      send_byte(VEC[v][25:18], 1'b0, a2);
      bus_stop();
      wq();
      chk($sformatf("R2 addr ack vec%0d", v), a0, VEC[v][1]);
      chk($sformatf("R8 cmd ack vec%0d", v), a1, VEC[v][1]);
      chk($sformatf("R8 data ack vec%0d", v), a2, VEC[v][1]);
      chk($sformatf("R4 R5 R6 wiper_a vec%0d", v), wiper_a, VEC[v][17:10]);
      chk($sformatf("R4 R5 R6 wiper_b vec%0d", v), wiper_b, VEC[v][9:2]);
      chk($sformatf("R12 strobes vec%0d", v), pcount - p0, VEC[v][0]);
      chk($sformatf("R8 released vec%0d", v), sda_pull_low, 0);
    end

    // R9: two data bytes to channel A
    p0 = pcount;
    bus_start();
    send_byte(8'h5A, 1'b0, a0);
    send_byte(8'h11, 1'b0, a1);
    send_byte(8'h10, 1'b0, a2);
    chk("R9 first data byte applied", wiper_a, 8'h10);
    send_byte(8'h20, 1'b0, a3);
    bus_stop();
    chk("R9 second data byte", wiper_a, 8'h20);
    chk("R9 second ack", a3, 1);
    chk("R9 strobe count", pcount - p0, 2);
    chk("R9 wiper_b untouched", wiper_b, 8'hFF);

    // R10: mismatched address, then repeated START with matching one
    bus_start();
    send_byte(8'h58, 1'b0, a0);
    chk("R10 mismatch no ack", a0, 0);
    bus_rstart();
    send_byte(8'h5A, 1'b0, a1);
    send_byte(8'h12, 1'b0, a2);
    send_byte(8'h77, 1'b0, a3);
    bus_stop();
    chk("R10 ack after restart", a1, 1);
    chk("R10 wiper_b after restart", wiper_b, 8'h77);

    // R10: restart in the middle of a write changes target
    bus_start();
    send_byte(8'h5A, 1'b0, a0);
    send_byte(8'h11, 1'b0, a1);
    bus_rstart();
    send_byte(8'h5A, 1'b0, a2);
    send_byte(8'h12, 1'b0, a3);
    send_byte(8'h33, 1'b0, a3);
    bus_stop();
    chk("R10 mid restart wiper_b", wiper_b, 8'h33);
    chk("R10 mid restart wiper_a kept", wiper_a, 8'h20);

    // R11: short glitches on both lines inside the data byte
    bus_start();
    send_byte(8'h5A, 1'b0, a0);
    send_byte(8'h11, 1'b0, a1);
    send_byte(8'h55, 1'b1, a2);
    bus_stop();
    chk("R11 glitched byte value", wiper_a, 8'h55);
    chk("R11 glitched byte ack", a2, 1);

    // R3: no-op with several data bytes
    p0 = pcount;
    bus_start();
    send_byte(8'h5B, 1'b0, a0);
    send_byte(8'h13, 1'b0, a1);
    send_byte(8'h01, 1'b0, a2);
    send_byte(8'h02, 1'b0, a3);
    bus_stop();
    chk("R3 nop wiper_a", wiper_a, 8'h55);
    chk("R3 nop wiper_b", wiper_b, 8'h33);
    chk("R3 nop strobes", pcount - p0, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule